// File: doc/BRIEF.md
# Cascadable Reload Timer Group

Three 8-bit down-counting timers share a small register bus. Each timer pairs a live counter with a reload latch. It counts on single-cycle enable ticks and divides its count source by n+1, where n is the latch value. When a count pulse arrives while the counter holds 0x00, the timer underflows. The counter then reloads from the latch and sets that timer's interrupt request flag.

Timer A always counts its own tick input. Timers B and C each have a mode bit that selects either their own tick input or timer A's underflow pulse, so the timers can be chained into longer dividers. Timer B has two extra features:
- A write mode in which a write loads only its latch. The counter picks up the new value at the next underflow.
- A toggle output that changes level on every timer B underflow.

Register map: address 0, 1 and 2 are timers A, B and C; address 3 is the mode register; address 4 holds the interrupt flags in bits 2:0. Write data is taken when `wr_en` is high. `rd_data` is registered and reflects the register selected by `addr` in the previous cycle.

Top module: `cascade_timer_group`

## Requirements
- R1: A timer whose counting is enabled decrements by one per count pulse. A count pulse while the counter is 0x00 is an underflow and reloads the counter from the latch, so the timer divides by latch+1.
- R2: A timer receiving no count pulse and no write keeps its count unchanged.
- R3: Writing address 0 (A), address 2 (C), or address 1 (B) while mode bit 2 is 0 loads the written value into both latch and counter in that cycle; the write takes precedence over a count pulse in the same cycle.
- R4: With mode bit 2 = 1, a write to address 1 loads only timer B's latch. The counter keeps counting and takes the new latch value at its next underflow.
- R5: With mode bit 2 = 1, a write to address 1 in the same cycle as a timer B underflow loads the written value into both latch and counter.
- R6: An underflow sets that timer's flag (address 4, bit 0 = A, bit 1 = B, bit 2 = C). Writing address 4 clears each flag whose data bit is 0 and leaves flags whose data bit is 1. A set in the same cycle as a clear wins.
- R7: Mode bit 0 (timer B) and mode bit 1 (timer C) select the count source: 0 = the timer's own tick input, 1 = timer A's underflow pulse in the same cycle. A mode change acts from the next cycle.
- R8: With mode bit 3 = 1, `tout` toggles on every timer B underflow. With mode bit 3 = 0, `tout` is held at 0.
- R9: After reset, all counters and latches hold 0xFF, the mode register and flags are 0, and `tout` is 0; timer B is therefore in the joint-write mode.
- R10: `rd_data` presents, one cycle after `addr` is applied, the live count of the addressed timer (not its latch), the mode register at address 3, the flags at address 4, and 0 at other addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 3 | Register address |
| wr_data | input | 8 | Write data |
| tick | input | 3 | Per-timer prescaled count tick, bit i for timer i |
| rd_data | output | 8 | Registered read data |
| irq | output | 3 | Interrupt request flags |
| tout | output | 1 | Timer B toggle output |

## Verification
The bench goes after four corner cases:
- A latch-only write to timer B in the exact cycle of its underflow. A design that ignored this collision would reload the old latch and lose the written value.
- A flag clear colliding with a fresh underflow. A design with the wrong priority would drop an interrupt.
- Chaining through timer A's underflow. An off-by-one-cycle cascade would make B or C count one pulse late.
- Reads that must show the live count. A design returning the latch would diverge as soon as counting starts.

Random ticks, writes and mode changes are compared every cycle against a cycle model kept in the bench.

// File: rtl/ctg_pkg.sv
package ctg_pkg;
  localparam int CTG_W      = 8;
  localparam int CTG_N      = 3;
  localparam int CTG_AW     = 3;
  localparam logic [CTG_AW-1:0] ADR_MODE = 3'd3;
  localparam logic [CTG_AW-1:0] ADR_FLAG = 3'd4;
  localparam int MB_LATCH_ONLY = CTG_N - 1;  // bit 2
  localparam int MB_TOUT_EN    = CTG_N;      // bit 3
endpackage

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cnt_en,
  input  logic         wr,
  input  logic [W-1:0] wr_val,
  input  logic         latch_only,
  output logic [W-1:0] count,
  output logic         uflow
);
  logic [W-1:0] latch_q;
  logic [W-1:0] cnt_q;

  assign uflow = cnt_en && (cnt_q == '0);
  assign count = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '1;
      cnt_q   <= '1;
    end else if (wr && (!latch_only || uflow)) begin
      latch_q <= wr_val;
      cnt_q   <= wr_val;
    end else begin
      if (wr) latch_q <= wr_val;
      if (cnt_en) cnt_q <= uflow ? latch_q : cnt_q - 1'b1;
    end
  end

  // R1: underflow reloads from latch when no write interferes
  a_r1_reload: assert property (@(posedge clk) disable iff (rst)
    (uflow && !wr) |=> (cnt_q == $past(latch_q)));
  // R1: plain count pulse decrements
  a_r1_decrement: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && !uflow && !wr) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R2: idle timer holds
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (!cnt_en && !wr) |=> $stable(cnt_q));
  // R4: latch-only write without underflow leaves the latch updated
  a_r4_latch_only: assert property (@(posedge clk) disable iff (rst)
    (wr && latch_only && !uflow) |=> (latch_q == $past(wr_val)));
  // R5: collision loads the counter
  a_r5_collision: assert property (@(posedge clk) disable iff (rst)
    (wr && latch_only && uflow) |=> (cnt_q == $past(wr_val)));
endmodule

// File: rtl/irq_bank.sv
module irq_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic         clr_wr,
  input  logic [N-1:0] keep_mask,
  output logic [N-1:0] flags
);
  always_ff @(posedge clk) begin
    if (rst)         flags <= '0;
    else if (clr_wr) flags <= (flags & keep_mask) | set;
    else             flags <= flags | set;
  end

  // R6: an underflow always leaves its flag set, even against a clear
  a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
    (set != '0) |=> ((flags & $past(set)) == $past(set)));
  // R6: without set or clear, flags hold
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (set == '0 && !clr_wr) |=> $stable(flags));
endmodule

// File: rtl/cascade_timer_group.sv
module cascade_timer_group
  import ctg_pkg::*;
#(
  parameter int W  = CTG_W,
  parameter int AW = CTG_AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wr_data,
  input  logic [2:0]    tick,
  output logic [W-1:0]  rd_data,
  output logic [2:0]    irq,
  output logic          tout
);
  localparam int N = CTG_N;

  logic [W-1:0] mode_q;
  logic [W-1:0] cnt [N];
  logic [N-1:0] uf;
  logic         uf_a;
  logic         tout_q;

  // Timer A: fixed tick source, joint write
  tmr_core #(.W(W)) u_tmr_a (
    .clk(clk), .rst(rst), .cnt_en(tick[0]),
    .wr(wr_en && addr == AW'(0)), .wr_val(wr_data),
    .latch_only(1'b0), .count(cnt[0]), .uflow(uf_a)
  );
  assign uf[0] = uf_a;

  // Timers B and C: source selectable, B may use latch-only writes
  for (genvar i = 1; i < N; i++) begin : g_tmr
    logic en_g;
    logic lo_g;
    assign en_g = mode_q[i-1] ? uf_a : tick[i];
    if (i == 1) begin : g_lo
      assign lo_g = mode_q[MB_LATCH_ONLY];
    end else begin : g_jw
      assign lo_g = 1'b0;
    end
    tmr_core #(.W(W)) u_tmr (
      .clk(clk), .rst(rst), .cnt_en(en_g),
      .wr(wr_en && addr == AW'(i)), .wr_val(wr_data),
      .latch_only(lo_g), .count(cnt[i]), .uflow(uf[i])
    );
  end

  irq_bank #(.N(N)) u_irq (
    .clk(clk), .rst(rst), .set(uf),
    .clr_wr(wr_en && addr == ADR_FLAG), .keep_mask(wr_data[N-1:0]),
    .flags(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= '0;
      tout_q  <= 1'b0;
      rd_data <= '0;
    end else begin
      if (wr_en && addr == ADR_MODE) mode_q <= wr_data;
      if (!mode_q[MB_TOUT_EN]) tout_q <= 1'b0;
      else if (uf[1])          tout_q <= ~tout_q;
      case (addr)
        AW'(0):   rd_data <= cnt[0];
        AW'(1):   rd_data <= cnt[1];
        AW'(2):   rd_data <= cnt[2];
        ADR_MODE: rd_data <= mode_q;
        ADR_FLAG: rd_data <= W'(irq);
        default:  rd_data <= '0;
      endcase
    end
  end
  assign tout = tout_q;

  // R8: toggle on B underflow while enabled
  a_r8_toggle: assert property (@(posedge clk) disable iff (rst)
    (uf[1] && mode_q[MB_TOUT_EN]) |=> (tout != $past(tout)));
  // R8: disabled output stays low
  a_r8_low: assert property (@(posedge clk) disable iff (rst)
    !mode_q[MB_TOUT_EN] |=> !tout);
  // R7: cascaded timer counts exactly on A's underflow
  a_r7_cascade: assert property (@(posedge clk) disable iff (rst)
    (mode_q[0] && !uf_a && !(wr_en && addr == AW'(1))) |=> $stable(cnt[1]));
  // R9: reset state
  a_r9_reset: assert property (@(posedge clk)
    $past(rst) |-> (irq == '0 && !tout && mode_q == '0));
endmodule

// File: tb/sim_cascade_timer_group.sv
module sim_cascade_timer_group;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] tick = '0;
  logic [7:0] rd_data;
  logic [2:0] irq;
  logic       tout;

  int n_chk = 0;
  int n_err = 0;
  int cycles = 0;

  cascade_timer_group u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .tick(tick), .rd_data(rd_data), .irq(irq), .tout(tout)
  );

  always #10 clk = ~clk;  // 50 MHz

  // Bench cycle model built from the requirements
  logic [7:0] mc [3];
  logic [7:0] ml [3];
  logic [7:0] mm, mrd;
  logic [2:0] mi;
  logic       mt;

  function automatic logic [7:0] next_cnt(logic [7:0] c, logic [7:0] l, logic en);
    if (!en) return c;
    return (c == 8'h00) ? l : c - 8'd1;
  endfunction

  always @(posedge clk) begin
    logic [2:0] en, u;
    logic [7:0] nc [3];
    logic [7:0] nl [3];
    cycles++;
    if (rst) begin
      for (int i = 0; i < 3; i++) begin mc[i] = 8'hFF; ml[i] = 8'hFF; end
      mm = 0; mi = 0; mt = 0; mrd = 0;
    end else begin
      en[0] = tick[0];
      u[0]  = en[0] && mc[0] == 0;
      en[1] = mm[0] ? u[0] : tick[1];
      en[2] = mm[1] ? u[0] : tick[2];
      u[1]  = en[1] && mc[1] == 0;
      u[2]  = en[2] && mc[2] == 0;
      case (addr)
        3'd0, 3'd1, 3'd2: mrd = mc[addr];
        3'd3: mrd = mm;
        3'd4: mrd = {5'd0, mi};
        default: mrd = 0;
      endcase
      for (int i = 0; i < 3; i++) begin
        nc[i] = next_cnt(mc[i], ml[i], en[i]);
        nl[i] = ml[i];
        if (wr_en && addr == 3'(i)) begin
          nl[i] = wr_data;
          if (!(i == 1 && mm[2]) || u[i]) nc[i] = wr_data;
        end
      end
      if (wr_en && addr == 3'd4) mi = (mi & wr_data[2:0]) | u;
      else mi = mi | u;
      if (!mm[3]) mt = 0; else if (u[1]) mt = ~mt;
      if (wr_en && addr == 3'd3) mm = wr_data;
      for (int i = 0; i < 3; i++) begin mc[i] = nc[i]; ml[i] = nl[i]; end
    end
  end

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, sample at the following negedge
  task automatic cyc(logic w, logic [2:0] a, logic [7:0] d, logic [2:0] t);
    wr_en = w; addr = a; wr_data = d; tick = t;
    @(negedge clk);
    if (!rst) begin
      check("R10/R1/R3 rd_data vs model", rd_data, mrd);
      check("R6 irq vs model", {5'd0, irq}, {5'd0, mi});
      check("R8 tout vs model", {7'd0, tout}, {7'd0, mt});
    end
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] v);
    cyc(1'b0, a, 8'h00, 3'b000);
    v = rd_data;
  endtask

  initial begin
    #(20 * 150000);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h1234_5678));
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    // R9: reset state
    rd(3'd0, v); check("R9 timer A after reset", v, 8'hFF);
    rd(3'd1, v); check("R9 timer B after reset", v, 8'hFF);
    rd(3'd3, v); check("R9 mode after reset", v, 8'h00);
    check("R9 irq after reset", {5'd0, irq}, 8'h00);
    check("R9 tout after reset", {7'd0, tout}, 8'h00);

    // R1/R3: timer A, latch 3, divide by 4
    cyc(1'b1, 3'd0, 8'd3, 3'b000);
    for (int k = 0; k < 3; k++) cyc(1'b0, 3'd0, 0, 3'b001);
    rd(3'd0, v); check("R1 A counted to zero", v, 8'd0);
    check("R6 no flag before underflow", {5'd0, irq}, 8'd0);
    cyc(1'b0, 3'd0, 0, 3'b001);
    rd(3'd0, v); check("R1 A reloaded after 4th tick", v, 8'd3);
    check("R6 A flag set", {5'd0, irq}, 8'd1);
    cyc(1'b1, 3'd4, 8'h06, 3'b000);
    check("R6 write 0 clears A flag", {5'd0, irq}, 8'd0);
    // R2: no tick holds
    cyc(1'b0, 3'd0, 0, 3'b000);
    rd(3'd0, v); check("R2 A holds without tick", v, 8'd3);

    // R5: B latch-only collision with underflow
    cyc(1'b1, 3'd1, 8'd0, 3'b000);          // joint write: B=0
    cyc(1'b1, 3'd3, 8'h04, 3'b000);         // latch-only mode
    cyc(1'b1, 3'd1, 8'd5, 3'b010);          // write in underflow cycle
    rd(3'd1, v); check("R5 collision loads counter", v, 8'd5);
    // R4: latch-only write leaves counter
    cyc(1'b1, 3'd1, 8'd9, 3'b000);
    rd(3'd1, v); check("R4 counter untouched by latch write", v, 8'd5);
    for (int k = 0; k < 6; k++) cyc(1'b0, 3'd1, 0, 3'b010);
    rd(3'd1, v); check("R4 new latch taken at underflow", v, 8'd9);
    // R6: set wins over clear
    cyc(1'b1, 3'd1, 8'd0, 3'b000);          // latch B = 0, counter still 9
    cyc(1'b1, 3'd3, 8'h00, 3'b000);         // joint mode
    cyc(1'b1, 3'd1, 8'd0, 3'b000);          // B = 0
    cyc(1'b1, 3'd4, 8'h00, 3'b010);         // clear all while B underflows
    check("R6 set wins over clear", {5'd0, irq}, 8'h02);

    // R7/R8: cascade B on A, toggle output
    cyc(1'b1, 3'd0, 8'd1, 3'b000);
    cyc(1'b1, 3'd1, 8'd1, 3'b000);
    cyc(1'b1, 3'd3, 8'h09, 3'b000);         // B from A, tout on
    for (int k = 0; k < 4; k++) cyc(1'b0, 3'd1, 0, 3'b011);
    rd(3'd1, v); check("R7 B counted A underflows only", v, 8'd1);
    check("R8 tout toggled once", {7'd0, tout}, 8'd1);

    // constrained random against the model
    for (int k = 0; k < 4000; k++) begin
      logic w;
      logic [2:0] a;
      w = ($urandom % 6) == 0;
      a = 3'($urandom % 6);
      cyc(w, a, (a == 3'd3) ? 8'($urandom % 16) : 8'($urandom % 8), 3'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule